// File: doc/BRIEF.md
# Paged I2C Register Slave

This block is an I2C target that gives a host reach into a 16-bit register space through an 8-bit offset window. The upper half of every register address comes from a page value held inside the block. The lower half is the offset the host sends at the start of each write transaction. One offset, 0xFF, is reserved on every page. Writing a byte there selects a new page, and reading it returns the page currently selected. Every other offset is passed to a parallel register port as an address, a byte of write data and a one-cycle write strobe. On reads, the block returns the byte that the register file presents on its read-data input.

A transaction begins with START and the 7-bit target address with the R/W bit. A write then carries an offset byte and any number of data bytes. The offset advances by one after each data byte and wraps within the page. A read first sets the offset with a one-byte write, then issues a repeated START and reads one or more bytes. The master ends the read with NACK. SCL and SDA are sampled on the system clock. SDA is driven low only through an open-drain enable.

The controller is a single state machine with these states:
- IDLE: wait for START.
- DEV: shift in the address byte.
- ACK_DEV: acknowledge the address.
- OFFS: shift in the offset byte.
- ACK_OFFS: acknowledge the offset.
- WR: shift in a data byte.
- ACK_WR: acknowledge the data byte, with the register write or page load taking effect on entry.
- RD: shift out a byte.
- RACK: sample the master's acknowledge.

The transitions are:
- IDLE to DEV on START.
- DEV to ACK_DEV on a full byte with a matching address, or DEV to IDLE on a mismatch.
- ACK_DEV to OFFS for a write, or ACK_DEV to RD for a read, at the end of the ACK clock.
- OFFS to ACK_OFFS to WR.
- WR to ACK_WR and back to WR.
- RD to RACK after eight bits.
- RACK to RD on ACK, or RACK to IDLE on NACK.
- From any state to DEV on START, and to IDLE on STOP.

Top module: `paged_i2c_regs`

## Requirements
- R1: After reset the page is 0xFF, the offset is 0x00 (so reg_addr reads 0xFF00), SDA is released and no write strobe is given.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA low in the ninth clock). Any other address is not acknowledged, and the bytes that follow cause no write strobe and no change of page.
- R3: In a write transaction, the first byte after the address is taken as the offset and is acknowledged.
- R4: Each data byte written to an offset other than 0xFF gives exactly one single-cycle reg_we pulse, with reg_addr = {page, offset} and reg_wdata equal to the byte.
- R5: A data byte written to offset 0xFF loads the page register whatever the current page is, and it raises no write strobe.
- R6: The offset increases by one after every data byte written or read. It wraps from 0xFF to 0x00 and never carries into the page.
- R7: A three-byte burst (offset, high byte, low byte) stores the high byte at the offset and the low byte at offset+1.
- R8: Read bytes are sent MSB first from consecutive offsets of the current page. Offset 0xFF returns the current page value.
- R9: When the master acknowledges a read byte, the next byte follows. When the master does not acknowledge, the block releases SDA and returns to idle.
- R10: START in any state restarts address reception, and STOP in any state returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When high, pull SDA low (open-drain) |
| reg_addr | output | 16 | Register address {page, offset} |
| reg_wdata | output | 8 | Write data for the register port |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register at reg_addr |

## Verification
The hardest situation to reach from the ports is a transfer that crosses offset 0xFF. The page byte then appears inside a read burst, and inside a write burst the page is reloaded before the offset wraps to 0x00 of the same page. The stimulus reaches this by setting the offset to 0xFE, reading three bytes across the boundary, and then writing three bytes across it with the current page value as the middle byte. Afterwards it checks the two outer registers and confirms that the page never carried. A second hard case is a transaction to a wrong address whose payload would reselect the page. The bench shows that nothing changed by reading offset 0xFF back afterwards.

// File: rtl/pgi2c_pkg.sv
package pgi2c_pkg;
    localparam int BYTE_W  = 8;
    localparam int PAGE_W  = 8;
    localparam int OFFS_W  = 8;
    localparam int RADDR_W = PAGE_W + OFFS_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [OFFS_W-1:0] PAGE_SEL_OFFS = '1;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_ACK_DEV, S_OFFS, S_ACK_OFFS,
        S_WR, S_ACK_WR, S_RD, S_RACK
    } state_t;
endpackage

// File: rtl/pgi2c_sync.sv
module pgi2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/pgi2c_ptr.sv
module pgi2c_ptr
    import pgi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              offs_ld,
    input  logic [OFFS_W-1:0] offs_in,
    input  logic              step,
    input  logic              page_ld,
    input  logic [PAGE_W-1:0] page_in,
    output logic [PAGE_W-1:0] page,
    output logic [OFFS_W-1:0] offs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '1;
            offs <= '0;
        end else begin
            if (page_ld) page <= page_in;
            if (offs_ld)   offs <= offs_in;
            else if (step) offs <= offs + 1'b1;
        end
    end
endmodule

// File: rtl/paged_i2c_regs.sv
module paged_i2c_regs
    import pgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [RADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_we,
    input  logic [BYTE_W-1:0]  reg_rdata
);
    logic sda_q, scl_rise, scl_fall, start_det, stop_det;
    state_t state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr, tx, rd_byte;
    logic rw_q, mack_q, bit_full, addr_hit;
    logic wr_evt, load_tx, offs_ld, step, page_ld, shift_in;
    logic [PAGE_W-1:0] page;
    logic [OFFS_W-1:0] offs;

    pgi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    pgi2c_ptr u_ptr (
        .clk(clk), .rst_n(rst_n),
        .offs_ld(offs_ld), .offs_in(sr[OFFS_W-1:0]), .step(step),
        .page_ld(page_ld), .page_in(sr[PAGE_W-1:0]),
        .page(page), .offs(offs)
    );

    assign bit_full = (cnt == CNT_W'(BYTE_W));
    assign addr_hit = (sr[7:1] == DEV_ADDR);
    assign shift_in = (state == S_DEV) || (state == S_OFFS) || (state == S_WR);

    // next state
    always_comb begin
        nxt = state;
        if (stop_det)       nxt = S_IDLE;
        else if (start_det) nxt = S_DEV;
        else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_DEV:      if (scl_fall && bit_full) nxt = addr_hit ? S_ACK_DEV : S_IDLE;
                S_ACK_DEV:  if (scl_fall) nxt = rw_q ? S_RD : S_OFFS;
                S_OFFS:     if (scl_fall && bit_full) nxt = S_ACK_OFFS;
                S_ACK_OFFS: if (scl_fall) nxt = S_WR;
                S_WR:       if (scl_fall && bit_full) nxt = S_ACK_WR;
                S_ACK_WR:   if (scl_fall) nxt = S_WR;
                S_RD:       if (scl_fall && bit_full) nxt = S_RACK;
                S_RACK:     if (scl_fall) nxt = mack_q ? S_RD : S_IDLE;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            sr     <= '0;
            tx     <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det || state != nxt)
                cnt <= '0;
            else if (scl_rise && !bit_full && (shift_in || state == S_RD))
                cnt <= cnt + 1'b1;
            if (scl_rise && shift_in)
                sr <= {sr[BYTE_W-2:0], sda_q};
            if (state == S_DEV && scl_fall && bit_full)
                rw_q <= sr[0];
            if (state == S_RACK && scl_rise)
                mack_q <= ~sda_q;
            if (load_tx)
                tx <= rd_byte;
            else if (state == S_RD && scl_fall && !bit_full)
                tx <= {tx[BYTE_W-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        wr_evt    = (state == S_WR) && (nxt == S_ACK_WR);
        load_tx   = (nxt == S_RD) && (state != S_RD);
        offs_ld   = (state == S_OFFS) && (nxt == S_ACK_OFFS);
        page_ld   = wr_evt && (offs == PAGE_SEL_OFFS);
        reg_we    = wr_evt && (offs != PAGE_SEL_OFFS);
        step      = wr_evt || load_tx;
        rd_byte   = (offs == PAGE_SEL_OFFS) ? page : reg_rdata;
        reg_wdata = sr;
        reg_addr  = {page, offs};
        sda_oe    = (state == S_ACK_DEV) || (state == S_ACK_OFFS) ||
                    (state == S_ACK_WR)  || ((state == S_RD) && !tx[BYTE_W-1]);
    end

    // R2: only a matching address is acknowledged
    p_ack_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_DEV) |-> (sr[7:1] == DEV_ADDR));

    // R4: the strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: page moves only after a byte at the select offset
    p_page_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[15:8] != $past(reg_addr[15:8])) |-> ($past(reg_addr[7:0]) == 8'hFF));

    // R6: offset advances after a write, page held
    p_offset_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> ((reg_addr[7:0] == 8'($past(reg_addr[7:0]) + 8'd1)) && $stable(reg_addr[15:8])));

    // R10: idle means bus released and no strobe
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!sda_oe && !reg_we));
endmodule

// File: tb/paged_i2c_regs_test.sv
module paged_i2c_regs_test;
    localparam logic [6:0] ADDR = 7'h48;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, reg_we;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [7:0]  mem [1024];
    int checks = 0, errors = 0, we_cnt = 0;
    logic [15:0] last_we_addr = '0;
    wire sda_bus = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    paged_i2c_regs #(.DEV_ADDR(ADDR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr[9:0]];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr[9:0]] <= reg_wdata;
            last_we_addr <= reg_addr;
            we_cnt <= we_cnt + 1;
        end
    end

    function automatic logic [7:0] init_val(input logic [9:0] a);
        return a[7:0] ^ {6'b0, a[9:8]} ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_rbyte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_bus; tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~give_ack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic wr_seq(input logic [7:0] offs, input logic [7:0] d0, input logic [7:0] d1,
                          input int n, input string req);
        logic a;
        i2c_start;
        i2c_wbyte({ADDR, 1'b0}, a); chk({req, " R2 addr ack"}, a, 1);
        i2c_wbyte(offs, a);         chk({req, " R3 offset ack"}, a, 1);
        i2c_wbyte(d0, a);           chk({req, " data ack"}, a, 1);
        if (n > 1) begin
            i2c_wbyte(d1, a);       chk({req, " data ack"}, a, 1);
        end
        i2c_stop;
    endtask

    task automatic set_offs_read(input logic [7:0] offs);
        logic a;
        i2c_start;
        i2c_wbyte({ADDR, 1'b0}, a); chk("R2 addr ack", a, 1);
        i2c_wbyte(offs, a);         chk("R3 offset ack", a, 1);
        i2c_start;
        i2c_wbyte({ADDR, 1'b1}, a); chk("R10 restart read ack", a, 1);
    endtask

    task automatic t_reset;
        chk("R1 reset addr", reg_addr, 16'hFF00);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 no strobe", we_cnt, 0);
    endtask

    task automatic t_page_write;
        int n0;
        n0 = we_cnt;
        wr_seq(8'hFF, 8'h01, 8'h00, 1, "R5 page select");
        chk("R5 no strobe on page write", we_cnt, n0);
        wr_seq(8'h10, 8'hA5, 8'h00, 1, "R4 write");
        chk("R4 single strobe", we_cnt, n0 + 1);
        chk("R4 strobe address", last_we_addr, 16'h0110);
        chk("R4 stored data", mem[10'h110], 8'hA5);
    endtask

    task automatic t_burst16;
        wr_seq(8'hFF, 8'h02, 8'h00, 1, "R5 page from page 1");
        wr_seq(8'h40, 8'h12, 8'h34, 2, "R7 burst");
        chk("R7 MSB at offset", mem[10'h240], 8'h12);
        chk("R7 LSB at offset+1", mem[10'h241], 8'h34);
        chk("R6 last address", last_we_addr, 16'h0241);
    endtask

    task automatic t_read;
        logic [7:0] b;
        set_offs_read(8'h40);
        i2c_rbyte(1'b1, b); chk("R8 read byte 0", b, 8'h12);
        i2c_rbyte(1'b1, b); chk("R9 read byte 1 after ack", b, 8'h34);
        i2c_rbyte(1'b0, b); chk("R8 read byte 2", b, init_val(10'h242));
        tick(Q);
        chk("R9 sda released after nack", sda_oe, 0);
        i2c_stop;
        chk("R10 idle after stop", sda_oe, 0);
    endtask

    task automatic t_wrap;
        logic [7:0] b;
        set_offs_read(8'hFE);
        i2c_rbyte(1'b1, b); chk("R6 read FE", b, init_val(10'h2FE));
        i2c_rbyte(1'b1, b); chk("R8 offset FF gives page", b, 8'h02);
        i2c_rbyte(1'b0, b); chk("R6 wrap to 00 same page", b, init_val(10'h200));
        i2c_stop;
        begin
            logic a;
            i2c_start;
            i2c_wbyte({ADDR, 1'b0}, a);
            i2c_wbyte(8'hFE, a);
            i2c_wbyte(8'h77, a);
            i2c_wbyte(8'h02, a);
            i2c_wbyte(8'h99, a); chk("R6 ack after wrap", a, 1);
            i2c_stop;
        end
        chk("R6 write at FE", mem[10'h2FE], 8'h77);
        chk("R6 write wrapped to 00", mem[10'h200], 8'h99);
        chk("R6 no carry into page", last_we_addr, 16'h0200);
    endtask

    task automatic t_wrong_addr;
        logic a;
        logic [7:0] b;
        int n0;
        n0 = we_cnt;
        i2c_start;
        i2c_wbyte({7'h21, 1'b0}, a); chk("R2 mismatch not acked", a, 0);
        i2c_wbyte(8'hFF, a);
        i2c_wbyte(8'h03, a);
        i2c_wbyte(8'h55, a);
        i2c_stop;
        chk("R2 no strobe on mismatch", we_cnt, n0);
        set_offs_read(8'hFF);
        i2c_rbyte(1'b0, b); chk("R2 page unchanged", b, 8'h02);
        i2c_stop;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = init_val(10'(i));
        tick(5);
        t_reset;
        rst_n = 1'b1;
        tick(5);
        t_reset;
        t_page_write;
        t_burst16;
        t_read;
        t_wrap;
        t_wrong_addr;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        finish_run;
    end
endmodule